// File: doc/BRIEF.md
# Thirty-Two Pin I/O Controller with Edge Interrupts

This block gives software control over thirty-two general-purpose pins through a small 32-bit register bus. Each pin can be made an output, which then drives a value held in a data register, or an input, whose pad level is brought into the clock domain by a two-flop synchronizer and can be read back. Any pin can also latch edge events. Software clears these with write-one-to-clear writes, enables them per pin with a mask, and sees them as one aggregated interrupt line.

Pin numbering is reversed against bit numbering: pin n lives in register bit 31 − n, so pin 0 is the most significant bit. A parameter selects one of two edge-sense layouts. In the compact layout each pin has a single control bit. In the wide layout each pin has a two-bit field, and the fields are spread over two registers. A second parameter names a set of pins that can never become outputs.

The bus is single-cycle. A write is taken on the rising clock edge while `busSel` and `busWr` are high. Read data is combinational and valid while `busSel` is high and `busWr` is low. At all other times it is zero.

Top module: `pinbank_top`

## Requirements
- R1: After reset the direction, data, event, mask and both edge-control registers read zero. `padOe` is zero and `irqOut` is low.
- R2: The direction register is at offset 0x00. A 1 in bit b makes pin 31 − b an output, and `padOe` equals this register. The data register is at offset 0x08, and `padOut` equals the last value written to it.
- R3: Bits named in the `INPUT_ONLY` parameter ignore writes of 1 to the direction register. They always read 0 there, and the matching `padOe` bit stays 0.
- R4: A read of offset 0x08 returns the last written data value for output bits. For input bits it returns the synchronized pad level, which follows a stable pad change after two clock edges.
- R5: A sensed edge on a pad sets the matching bit of the event register at offset 0x0C. The bit is set on the third rising clock edge after the pad changes, and it stays set until cleared. Writing 1 to an event bit clears it, and writing 0 leaves it unchanged.
- R6: When an edge sets an event bit on the same clock edge as a clearing write to that bit, the bit stays set. Other bits named in the same write are still cleared.
- R7: `irqOut` is high exactly when the bitwise AND of the event register and the mask register (offset 0x10) is nonzero. A mask bit of 1 enables its pin.
- R8: In one-bit sense mode, bit b of the edge-control register at 0x14 set to 1 latches only falling edges, and set to 0 latches both edges. Offset 0x18 reads 0 and ignores writes in this mode.
- R9: In two-bit sense mode, pins 0–15 take their field from 0x14 and pins 16–31 take theirs from 0x18. The field sits at bit (15 − (pin mod 16)) × 2. Field value 0 selects both edges, 1 selects rising, 2 selects falling, and 3 selects no edge.
- R10: Reads of unmapped offsets (for example 0x04 and 0x1C) return zero, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busSel | input | 1 | Bus access select |
| busWr | input | 1 | 1 = write, 0 = read |
| busAddr | input | 5 | Byte offset of the register |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, zero when not reading |
| padIn | input | 32 | Asynchronous pad levels |
| padOut | output | 32 | Output values to pad drivers |
| padOe | output | 32 | Output enables to pad drivers |
| irqOut | output | 1 | Aggregated interrupt request |

## Verification
The hardest situation to reach from the ports is a clearing write that lands on the same clock edge where a fresh pad edge reaches the event register. This needs the bus write to be placed exactly three edges after the pad change. A directed sequence toggles a pad at a falling clock edge, waits two cycles, and issues the all-ones clear so that it lands on that edge. Random phases then mix direction, data, mask and edge-control writes with sparse pad flips. The edge-control values are random, so every two-bit field value, field value 3 included, is met on both pin halves.

// File: rtl/pinbank_pkg.sv
package pinbank_pkg;
  localparam int PIN_COUNT = 32;
  localparam int ADDR_W    = 5;
  localparam int HALF      = PIN_COUNT / 2;

  localparam logic [ADDR_W-1:0] OFS_DIR   = 5'h00;
  localparam logic [ADDR_W-1:0] OFS_DATA  = 5'h08;
  localparam logic [ADDR_W-1:0] OFS_EVT   = 5'h0C;
  localparam logic [ADDR_W-1:0] OFS_MASK  = 5'h10;
  localparam logic [ADDR_W-1:0] OFS_EDGEA = 5'h14;
  localparam logic [ADDR_W-1:0] OFS_EDGEB = 5'h18;

  typedef enum logic [2:0] {
    RD_NONE, RD_DIR, RD_DATA, RD_EVT, RD_MASK, RD_EDGEA, RD_EDGEB
  } rdSel_e;

  typedef struct packed {
    logic   wrDir;
    logic   wrData;
    logic   clrEvt;
    logic   wrMask;
    logic   wrEdgeA;
    logic   wrEdgeB;
    rdSel_e rdSel;
  } strobe_t;
endpackage

// File: rtl/pinbank_ctrl.sv
module pinbank_ctrl
  import pinbank_pkg::*;
#(
  parameter bit SENSE_TWO_BIT = 1'b1
) (
  input  logic              busSel,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  output strobe_t           strobe
);
  logic wrAcc;
  logic rdAcc;
  logic edgeBMapped;

  assign wrAcc       = busSel & busWr;
  assign rdAcc       = busSel & ~busWr;
  assign edgeBMapped = SENSE_TWO_BIT;

  always_comb begin
    strobe         = '0;
    strobe.rdSel   = RD_NONE;
    strobe.wrDir   = wrAcc && (busAddr == OFS_DIR);
    strobe.wrData  = wrAcc && (busAddr == OFS_DATA);
    strobe.clrEvt  = wrAcc && (busAddr == OFS_EVT);
    strobe.wrMask  = wrAcc && (busAddr == OFS_MASK);
    strobe.wrEdgeA = wrAcc && (busAddr == OFS_EDGEA);
    strobe.wrEdgeB = wrAcc && edgeBMapped && (busAddr == OFS_EDGEB);
    if (rdAcc) begin
      unique case (busAddr)
        OFS_DIR:   strobe.rdSel = RD_DIR;
        OFS_DATA:  strobe.rdSel = RD_DATA;
        OFS_EVT:   strobe.rdSel = RD_EVT;
        OFS_MASK:  strobe.rdSel = RD_MASK;
        OFS_EDGEA: strobe.rdSel = RD_EDGEA;
        OFS_EDGEB: strobe.rdSel = edgeBMapped ? RD_EDGEB : RD_NONE;
        default:   strobe.rdSel = RD_NONE;
      endcase
    end
  end
endmodule

// File: rtl/pinbank_dp.sv
module pinbank_dp
  import pinbank_pkg::*;
#(
  parameter bit                   SENSE_TWO_BIT = 1'b1,
  parameter logic [PIN_COUNT-1:0] INPUT_ONLY    = 32'h0000_000F
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  strobe_t              strobe,
  input  logic [PIN_COUNT-1:0] wdata,
  input  logic [PIN_COUNT-1:0] padIn,
  output logic [PIN_COUNT-1:0] rdata,
  output logic [PIN_COUNT-1:0] padOut,
  output logic [PIN_COUNT-1:0] padOe,
  output logic                 irqOut
);
  logic [PIN_COUNT-1:0] dirReg, outReg, evtReg, maskReg, edgeA, edgeB;
  logic [PIN_COUNT-1:0] syncA, syncB, syncPrev;
  logic [PIN_COUNT-1:0] riseVec, fallVec, riseEn, fallEn, hitVec, clrVec;

  assign riseVec = syncB & ~syncPrev;
  assign fallVec = ~syncB & syncPrev;

  // Per-bit sense decode; bit b belongs to pin (PIN_COUNT-1-b)
  for (genvar b = 0; b < PIN_COUNT; b++) begin : g_sense
    if (SENSE_TWO_BIT) begin : g_wide
      logic [1:0] field;
      if (b >= HALF) begin : g_lowPins
        assign field = edgeA[2*(b-HALF) +: 2];
      end else begin : g_highPins
        assign field = edgeB[2*b +: 2];
      end
      assign riseEn[b] = (field == 2'd0) || (field == 2'd1);
      assign fallEn[b] = (field == 2'd0) || (field == 2'd2);
    end else begin : g_narrow
      assign riseEn[b] = ~edgeA[b];
      assign fallEn[b] = 1'b1;
    end
  end

  assign hitVec = (riseVec & riseEn) | (fallVec & fallEn);
  assign clrVec = strobe.clrEvt ? wdata : '0;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      dirReg   <= '0;
      outReg   <= '0;
      evtReg   <= '0;
      maskReg  <= '0;
      edgeA    <= '0;
      edgeB    <= '0;
      syncA    <= '0;
      syncB    <= '0;
      syncPrev <= '0;
    end else begin
      syncA    <= padIn;
      syncB    <= syncA;
      syncPrev <= syncB;
      if (strobe.wrDir)   dirReg  <= wdata & ~INPUT_ONLY;
      if (strobe.wrData)  outReg  <= wdata;
      if (strobe.wrMask)  maskReg <= wdata;
      if (strobe.wrEdgeA) edgeA   <= wdata;
      if (strobe.wrEdgeB) edgeB   <= wdata;
      evtReg <= (evtReg & ~clrVec) | hitVec;
    end
  end

  always_comb begin
    unique case (strobe.rdSel)
      RD_DIR:   rdata = dirReg;
      RD_DATA:  rdata = (outReg & dirReg) | (syncB & ~dirReg);
      RD_EVT:   rdata = evtReg;
      RD_MASK:  rdata = maskReg;
      RD_EDGEA: rdata = edgeA;
      RD_EDGEB: rdata = edgeB;
      default:  rdata = '0;
    endcase
  end

  assign padOut = outReg;
  assign padOe  = dirReg;
  assign irqOut = |(evtReg & maskReg);

  p_sticky_r5: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.clrEvt |=> ((evtReg & $past(evtReg)) == $past(evtReg)));

  p_clear_r5: assert property (@(posedge clk) disable iff (!rstN)
    strobe.clrEvt |=> ((evtReg & $past(wdata & ~hitVec)) == '0));

  p_edge_wins_r6: assert property (@(posedge clk) disable iff (!rstN)
    (hitVec != '0) |=> ((evtReg & $past(hitVec)) == $past(hitVec)));
endmodule

// File: rtl/pinbank_top.sv
module pinbank_top
  import pinbank_pkg::*;
#(
  parameter bit                   SENSE_TWO_BIT = 1'b1,
  parameter logic [PIN_COUNT-1:0] INPUT_ONLY    = 32'h0000_000F
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 busSel,
  input  logic                 busWr,
  input  logic [ADDR_W-1:0]    busAddr,
  input  logic [PIN_COUNT-1:0] busWdata,
  output logic [PIN_COUNT-1:0] busRdata,
  input  logic [PIN_COUNT-1:0] padIn,
  output logic [PIN_COUNT-1:0] padOut,
  output logic [PIN_COUNT-1:0] padOe,
  output logic                 irqOut
);
  strobe_t strobe;

  pinbank_ctrl #(.SENSE_TWO_BIT(SENSE_TWO_BIT)) uCtrl (
    .busSel (busSel),
    .busWr  (busWr),
    .busAddr(busAddr),
    .strobe (strobe)
  );

  pinbank_dp #(.SENSE_TWO_BIT(SENSE_TWO_BIT), .INPUT_ONLY(INPUT_ONLY)) uDp (
    .clk   (clk),
    .rstN  (rstN),
    .strobe(strobe),
    .wdata (busWdata),
    .padIn (padIn),
    .rdata (busRdata),
    .padOut(padOut),
    .padOe (padOe),
    .irqOut(irqOut)
  );

  p_inonly_r3: assert property (@(posedge clk) disable iff (!rstN)
    (padOe & INPUT_ONLY) == '0);

  p_readback_r4: assert property (@(posedge clk) disable iff (!rstN)
    (busSel && !busWr && busAddr == OFS_DATA) |-> ((busRdata & padOe) == (padOut & padOe)));

  p_quiet_r10: assert property (@(posedge clk) disable iff (!rstN)
    (busSel && !busWr && (busAddr == 5'h04 || busAddr == 5'h1C)) |-> (busRdata == '0));
endmodule

// File: tb/sim_pinbank_top.sv
`timescale 1ns/1ps
module sim_pinbank_top;
  localparam logic [31:0] INONLY0 = 32'h0000_000F;
  localparam logic [31:0] INONLY1 = 32'hF000_0000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busSel = 1'b0, busWr = 1'b0;
  logic [4:0]  busAddr = '0;
  logic [31:0] busWdata = '0, padIn = '0;
  logic [31:0] rd0, rd1, pOut0, pOut1, pOe0, pOe1;
  logic        irq0, irq1;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // Model state
  logic [31:0] mDir0, mDir1, mOut, mEvt0, mEvt1, mMask, mEdgeA, mEdgeB, mPad;

  always #2.5 clk = ~clk;

  pinbank_top #(.SENSE_TWO_BIT(1'b1), .INPUT_ONLY(INONLY0)) u0 (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWr(busWr), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(rd0), .padIn(padIn), .padOut(pOut0),
    .padOe(pOe0), .irqOut(irq0));

  pinbank_top #(.SENSE_TWO_BIT(1'b0), .INPUT_ONLY(INONLY1)) u1 (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWr(busWr), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(rd1), .padIn(padIn), .padOut(pOut1),
    .padOe(pOe1), .irqOut(irq1));

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s actual=%08h expected=%08h", tag, got, exp);
    end
  endtask

  function automatic logic [31:0] modelHit(input bit two, input logic [31:0] r,
      input logic [31:0] f, input logic [31:0] eA, input logic [31:0] eB);
    logic [31:0] h = '0;
    for (int b = 0; b < 32; b++) begin
      logic [1:0] fld;
      logic rE, fE;
      if (two) begin
        fld = (b >= 16) ? eA[2*(b-16) +: 2] : eB[2*b +: 2];
        rE = (fld == 2'd0) || (fld == 2'd1);
        fE = (fld == 2'd0) || (fld == 2'd2);
      end else begin
        rE = ~eA[b];
        fE = 1'b1;
      end
      h[b] = (r[b] & rE) | (f[b] & fE);
    end
    return h;
  endfunction

  function automatic logic [31:0] modelData(input logic [31:0] dir);
    return (mOut & dir) | (mPad & ~dir);
  endfunction

  task automatic busWrite(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    busSel = 1; busWr = 1; busAddr = a; busWdata = d;
    @(negedge clk);
    busSel = 0; busWr = 0;
    case (a)
      5'h00: begin mDir0 = d & ~INONLY0; mDir1 = d & ~INONLY1; end
      5'h08: mOut = d;
      5'h0C: begin mEvt0 &= ~d; mEvt1 &= ~d; end
      5'h10: mMask = d;
      5'h14: mEdgeA = d;
      5'h18: mEdgeB = d;
      default: ;
    endcase
  endtask

  task automatic busRead(input logic [4:0] a, output logic [31:0] r0, output logic [31:0] r1);
    @(negedge clk);
    busSel = 1; busWr = 0; busAddr = a;
    #1;
    r0 = rd0; r1 = rd1;
    busSel = 0;
  endtask

  task automatic setPads(input logic [31:0] nv);
    logic [31:0] r, f;
    @(negedge clk);
    padIn = nv;
    repeat (4) @(negedge clk);
    r = nv & ~mPad;
    f = ~nv & mPad;
    mEvt0 |= modelHit(1'b1, r, f, mEdgeA, mEdgeB);
    mEvt1 |= modelHit(1'b0, r, f, mEdgeA, 32'h0);
    mPad = nv;
  endtask

  task automatic checkAll(input string ctx);
    logic [31:0] a0, a1;
    busRead(5'h00, a0, a1);
    check({"R2 R3 dir u0 ", ctx}, a0, mDir0);
    check({"R3 dir u1 ", ctx}, a1, mDir1);
    busRead(5'h08, a0, a1);
    check({"R4 data u0 ", ctx}, a0, modelData(mDir0));
    check({"R4 data u1 ", ctx}, a1, modelData(mDir1));
    busRead(5'h0C, a0, a1);
    check({"R5 R9 evt u0 ", ctx}, a0, mEvt0);
    check({"R5 R8 evt u1 ", ctx}, a1, mEvt1);
    busRead(5'h10, a0, a1);
    check({"R7 mask ", ctx}, a0, mMask);
    busRead(5'h14, a0, a1);
    check({"R9 edgeA u0 ", ctx}, a0, mEdgeA);
    check({"R8 edge u1 ", ctx}, a1, mEdgeA);
    busRead(5'h18, a0, a1);
    check({"R9 edgeB u0 ", ctx}, a0, mEdgeB);
    check({"R8 edgeB u1 ", ctx}, a1, 32'h0);
    check({"R2 padOe u0 ", ctx}, pOe0, mDir0);
    check({"R3 padOe u1 ", ctx}, pOe1, mDir1);
    check({"R2 padOut ", ctx}, pOut0, mOut);
    check({"R7 irq u0 ", ctx}, {31'd0, irq0}, {31'd0, |(mEvt0 & mMask)});
    check({"R7 irq u1 ", ctx}, {31'd0, irq1}, {31'd0, |(mEvt1 & mMask)});
  endtask

  initial begin : watchdog
    int cyc = 0;
    while (!done && cyc < 150000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=completion", cyc);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : main
    logic [31:0] a0, a1;
    void'($urandom(32'd4711));
    mDir0 = 0; mDir1 = 0; mOut = 0; mEvt0 = 0; mEvt1 = 0;
    mMask = 0; mEdgeA = 0; mEdgeB = 0; mPad = 0;
    repeat (4) @(negedge clk);
    rstN = 1;

    // R1: reset state
    checkAll("R1 reset");
    check("R1 irq low", {30'd0, irq0, irq1}, 32'd0);

    // R2/R3: pin 0 is bit 31; u1 has pins 0-3 input only
    busWrite(5'h00, 32'h8000_0001);
    check("R2 pin0 oe u0", {31'd0, pOe0[31]}, 32'd1);
    check("R3 pin31 blocked u0", {31'd0, pOe0[0]}, 32'd0);
    check("R3 pin0 blocked u1", {31'd0, pOe1[31]}, 32'd0);
    check("R2 pin31 oe u1", {31'd0, pOe1[0]}, 32'd1);

    // R10: unmapped offsets
    busWrite(5'h04, 32'hFFFF_FFFF);
    busWrite(5'h1C, 32'hFFFF_FFFF);
    busRead(5'h04, a0, a1);
    check("R10 read 0x04 u0", a0, 32'h0);
    check("R10 read 0x04 u1", a1, 32'h0);
    busRead(5'h1C, a0, a1);
    check("R10 read 0x1C u0", a0, 32'h0);
    checkAll("R10 after stray writes");

    // R4: input readback after two edges
    @(negedge clk);
    padIn = 32'h0000_0F00;
    @(negedge clk); @(negedge clk);
    busSel = 1; busWr = 0; busAddr = 5'h08; #1;
    check("R4 sync two edges", rd0 & 32'h0000_0F00, 32'h0000_0F00);
    busSel = 0;
    repeat (2) @(negedge clk);
    mEvt0 |= modelHit(1'b1, 32'h0000_0F00, 32'h0, mEdgeA, mEdgeB);
    mEvt1 |= modelHit(1'b0, 32'h0000_0F00, 32'h0, mEdgeA, 32'h0);
    mPad = 32'h0000_0F00;
    checkAll("R4 R5 directed rise");

    // R9: pin 0 rising only, pin 16 falling only, pin 1 none
    busWrite(5'h0C, 32'hFFFF_FFFF);
    busWrite(5'h14, 32'h7000_0000);
    busWrite(5'h18, 32'h8000_0000);
    busWrite(5'h10, 32'hFFFF_FFFF);
    setPads(mPad | 32'hC000_8000);
    checkAll("R9 fields rise");
    setPads(mPad & ~32'hC000_8000);
    checkAll("R9 fields fall");

    // R6: clear collides with a new edge
    busWrite(5'h14, 32'h0);
    busWrite(5'h18, 32'h0);
    busWrite(5'h0C, 32'hFFFF_FFFF);
    setPads(mPad ^ 32'h0000_0002);
    @(negedge clk);
    padIn = mPad ^ 32'h0000_0001;
    @(negedge clk);
    @(negedge clk);
    busSel = 1; busWr = 1; busAddr = 5'h0C; busWdata = 32'hFFFF_FFFF;
    @(negedge clk);
    busSel = 0; busWr = 0;
    mEvt0 = 32'h0000_0001;
    mEvt1 = 32'h0000_0001;
    mPad = mPad ^ 32'h0000_0001;
    busRead(5'h0C, a0, a1);
    check("R6 edge beats clear u0", a0, 32'h0000_0001);
    check("R6 edge beats clear u1", a1, 32'h0000_0001);
    check("R7 irq after collision", {31'd0, irq0}, 32'd1);
    busWrite(5'h10, 32'h0);
    check("R7 masked irq low", {31'd0, irq0}, 32'd0);

    // Random phase
    for (int i = 0; i < 400; i++) begin
      int op;
      op = $urandom % 8;
      case (op)
        0: busWrite(5'h00, $urandom);
        1: busWrite(5'h08, $urandom);
        2: busWrite(5'h0C, $urandom | $urandom);
        3: busWrite(5'h10, $urandom & $urandom);
        4: busWrite(5'h14, $urandom);
        5: busWrite(5'h18, $urandom);
        default: setPads(mPad ^ ($urandom & $urandom & $urandom));
      endcase
      if (i % 4 == 3) checkAll("random");
    end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule